// File: doc/BRIEF.md
# Two-Stage Cascaded Interval Timer

This block produces a periodic interrupt from a low-speed auxiliary clock (nominally 32768 Hz) that drives `clk` directly. Two cascaded 8-bit counters form the divide chain. The first stage free-runs. The second stage advances either on every clock or, when the chain bit of the control byte is set, only on the first stage's carry. In the second case the first stage acts as a fixed divide-by-256 prescaler.

A 3-bit tap field in the control byte picks how many low bits of the second stage make up one interval. When those bits roll over, one interval has elapsed. The block then sets a sticky interrupt flag. The interrupt output is that flag gated by an enable input. With the prescaler on and the tap on divide-by-16, the total division is 4096, which gives eight interrupts per second (every 125 ms) at 32768 Hz.

Software writes the control byte through a one-cycle write strobe. Every write restarts both counter stages, so the first interval after a write is a full one. The interrupt controller pulses `flag_clr` when it acknowledges the interrupt.

Top module: `itmr_top`

## Requirements
- R1: After reset, `irq_flag` and `irq` are 0, the chain bit is 0 and the tap field is 0.
- R2: With the chain bit (control bit 7) at 0, the second stage advances every clock. The first flag set occurs exactly 2^(s+1) clocks after the write edge, where s is the tap field. Later sets follow every 2^(s+1) clocks.
- R3: With the chain bit at 1, the second stage advances once per 256 clocks. The interval becomes 256 x 2^(s+1) clocks; tap value 3 gives 4096.
- R4: The tap field is control bits [2:0]. Each value s in 0..7 selects a second-stage division of 2^(s+1) (2, 4, ..., 256).
- R5: A control write clears both stages to zero on the write edge, so a rewrite in mid-interval restarts a full interval. No flag set comes from the write cycle itself.
- R6: A `flag_clr` pulse clears the flag on the next edge. If an interval ends in the same cycle as the clear, the flag stays set.
- R7: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1. `irq_en` has no effect on the flag.
- R8: Control bits [6:3] have no effect on timing.
- R9: The flag stays set through further intervals until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Auxiliary timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: bit 7 chain, bits 2:0 tap |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Flag clear / acknowledge pulse |
| irq_flag | output | 1 | Sticky interval flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the exact cycle of the first flag set for every tap value, with and without the prescaler. An off-by-one in the tap mask would show up as an interval half or twice as long. A rollover detector that watches the rising edge of the tap bit would fire after only half an interval. A rewrite in mid-interval must push the next set a full interval out; a design that failed to restart the stages would set the flag early. The bench also checks that a set and a clear in the same cycle leave the flag set, and that the reserved control bits are ignored. A design that let the clear win would drop an interrupt. A design that decoded the wrong bits would change the interval.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CTL_W     = 8;
  localparam int TAP_W     = 3;
  localparam int CHAIN_POS = CTL_W - 1;

  typedef struct packed {
    logic             chain;
    logic [CTL_W-TAP_W-2:0] spare;
    logic [TAP_W-1:0] tap;
  } itmr_ctl_t;
endpackage

// File: rtl/itmr_rst_sync.sv
module itmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic carry_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i) cnt_d = '0;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign carry_o = &cnt_q;

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0)); // R5
  AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> (cnt_q == $past(cnt_q) + W'(1))); // R3
endmodule

// File: rtl/itmr_tap_stage.sv
module itmr_tap_stage #(
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  output logic             wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] mask;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      mask[i] = (tap_sel_i >= SEL_W'(i));
    end
  end

  always_comb begin
    if (restart_i)   cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wrap_o = step_i && !restart_i && ((cnt_q & mask) == mask);

  AST_TAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0)); // R5
  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !step_i) |=> $stable(cnt_q)); // R3
  AST_TAP_NO_EARLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !wrap_o); // R5
endmodule

// File: rtl/itmr_flag.sv
module itmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R9
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int ST1_W = 8,
  parameter int ST2_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             irq_flag,
  output logic             irq
);
  localparam int SEL_W = (ST2_W > 1) ? $clog2(ST2_W) : 1;

  logic      rst_s_n;
  itmr_ctl_t ctl_q, ctl_d;
  logic      carry, step, wrap;

  itmr_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n));

  always_comb begin
    if (ctl_we) ctl_d = itmr_ctl_t'(ctl_wdata);
    else        ctl_d = ctl_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ctl_q <= '0;
    else          ctl_q <= ctl_d;
  end

  itmr_prescale #(.W(ST1_W)) u_pre (
    .clk(clk), .rst_n(rst_s_n), .restart_i(ctl_we), .carry_o(carry)
  );

  assign step = ctl_q.chain ? carry : 1'b1;

  itmr_tap_stage #(.W(ST2_W), .SEL_W(SEL_W)) u_tap (
    .clk(clk), .rst_n(rst_s_n), .restart_i(ctl_we), .step_i(step),
    .tap_sel_i(SEL_W'(ctl_q.tap)), .wrap_o(wrap)
  );

  itmr_flag u_flag (
    .clk(clk), .rst_n(rst_s_n), .set_i(wrap), .clr_i(flag_clr), .flag_o(irq_flag)
  );

  assign irq = irq_flag & irq_en;

  AST_WRITE_NO_SET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl_we && !irq_flag && flag_clr) |=> !irq_flag); // R5
endmodule

// File: tb/sim_itmr_top.sv
module sim_itmr_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic       irq_en;
  logic       flag_clr;
  logic       irq_flag;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  itmr_top u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .irq_en(irq_en), .flag_clr(flag_clr), .irq_flag(irq_flag), .irq(irq)
  );

  // {control byte, expected interval in clocks}
  localparam logic [39:0] VEC [12] = '{
    {8'h00, 32'd2},   {8'h01, 32'd4},   {8'h02, 32'd8},   {8'h03, 32'd16},
    {8'h04, 32'd32},  {8'h05, 32'd64},  {8'h06, 32'd128}, {8'h07, 32'd256},
    {8'h7A, 32'd8},   {8'h83, 32'd4096}, {8'h80, 32'd512}, {8'hF9, 32'd1024}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v; flag_clr = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clr_pulse();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = 8'h00; irq_en = 1'b1; flag_clr = 1'b0;
    edges(3);
    chk("R1 flag in reset", irq_flag, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    edges(3);
    // R1: default tap 0 free-runs: flag must appear within 2 clocks
    edges(2);
    chk("R1 default interval", irq_flag, 1'b1);

    // Table walk: R2 R3 R4 R8
    for (int k = 0; k < 12; k++) begin
      logic [7:0] c;
      int p;
      c = VEC[k][39:32];
      p = int'(VEC[k][31:0]);
      write_ctl(c);
      edges(p - 1);
      chk($sformatf("R4 ctl=%02h before first interval", c), irq_flag, 1'b0);
      edges(1);
      chk($sformatf("R2/R3 ctl=%02h first interval", c), irq_flag, 1'b1);
      clr_pulse();
      chk($sformatf("R6 ctl=%02h cleared", c), irq_flag, 1'b0);
      edges(p - 2);
      chk($sformatf("R8 ctl=%02h before second interval", c), irq_flag, 1'b0);
      edges(1);
      chk($sformatf("R2 ctl=%02h second interval", c), irq_flag, 1'b1);
    end

    // R5: rewrite in mid-interval restarts a full interval
    write_ctl(8'h03);
    edges(10);
    write_ctl(8'h03);
    edges(15);
    chk("R5 no early set after rewrite", irq_flag, 1'b0);
    edges(1);
    chk("R5 full interval after rewrite", irq_flag, 1'b1);

    // R6: set and clear in the same cycle -> set wins
    write_ctl(8'h00);
    edges(2);
    chk("R6 flag set", irq_flag, 1'b1);
    edges(1);
    clr_pulse();
    chk("R6 set beats clear", irq_flag, 1'b1);
    write_ctl(8'h07);
    chk("R6 clear with no set", irq_flag, 1'b0);

    // R9: sticky across intervals
    write_ctl(8'h00);
    edges(7);
    chk("R9 sticky flag", irq_flag, 1'b1);

    // R7: enable gating
    irq_en = 1'b0;
    #1;
    chk("R7 irq masked", irq, 1'b0);
    chk("R7 flag unaffected by enable", irq_flag, 1'b1);
    irq_en = 1'b1;
    #1;
    chk("R7 irq asserted", irq, 1'b1);
    irq_en = 1'b0;
    write_ctl(8'h01);
    edges(4);
    chk("R7 flag sets with enable low", irq_flag, 1'b1);

    // R1: reset mid-run clears the flag
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears flag", irq_flag, 1'b0);
    edges(2);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule